// File: doc/BRIEF.md
# Tagged Reconfigurable Function Unit Dispatch

This block is the dispatch side of a reconfigurable function unit that sits beside a processor's register file. It holds a small store of rows. Each row is programmed through a configuration write port with an operation tag, up to three source register indices and a function select drawn from a fixed menu. Every row watches the register file write port. When a register that one of its sources names is written, the row captures the value at once, so it computes on live data long before any instruction asks for it.

When the pipeline issues a custom opcode, the block compares the opcode with the tags of the loaded rows. If a row matches and its result is already valid, the result goes onto the writeback bus in the same cycle. If a row matches but its operands are still outstanding, the block stalls the pipeline and then delivers the result in the first cycle it becomes valid. If no row matches, the block stalls and flags a miss, and it keeps doing so until a row carrying that tag is loaded.

A three-state controller sequences the issue side. IDLE handles fresh lookups. WAIT stalls on one locked row. MISS stalls and flags a miss while it repeats the lookup every cycle. The transitions are:
- IDLE→WAIT on a hit whose result is not ready.
- IDLE→MISS on a lookup with no match.
- WAIT→IDLE when the locked row becomes valid or the issue is withdrawn.
- MISS→WAIT when a matching row appears that is not ready.
- MISS→IDLE when a matching row appears that is ready, or when the issue is withdrawn.
- Each state holds otherwise.

Top module: `rfu_dispatch`

## Requirements
- R1: After reset no row is loaded. With `iss_valid` low, `stall`, `miss` and `wb_valid` are all low. Any opcode issued before a row is loaded is a miss.
- R2: A configuration write installs tag, sources and select into row `cfg_row` and marks the row loaded. It also clears that row's operand-ready state and result-valid state, and this takes priority over a register write at the same clock edge.
- R3: A register write whose index equals a source index of a loaded row captures `rf_wdata` into that source slot and marks the slot ready. `cfg_srcs` bits [4:0] give slot 0, bits [9:5] give slot 1 and bits [14:10] give slot 2.
- R4: A row's result becomes valid at the clock edge after the last edge at which one of its used source slots was written, provided all used slots are ready. Select 4 uses slot 0 only, select 5 uses all three slots, and every other select uses slots 0 and 1. A write to a used slot leaves the result invalid for one cycle.
- R5: The row result is computed from slot a=0, b=1, c=2 by select: 0 gives a+b, 1 gives a^b, 2 gives a&b, 3 gives a|b, 4 gives a with bit order reversed, 5 gives a+b+c, and 6 or 7 give zero. All sums wrap modulo 2^32.
- R6: An issued opcode that hits a row with a valid result drives `wb_valid` high and `wb_data` to that row's result in the same cycle, with `stall` low.
- R7: An issued opcode that hits a row with no valid result raises `stall` with `miss` low. The stall holds while the issue is held, and the result is written back in the first cycle the row's result is valid.
- R8: An issued opcode that matches no loaded row raises both `stall` and `miss`. These stay high while the issue is held and no loaded row matches.
- R9: When several loaded rows carry the issued tag, the lowest-numbered row supplies the result.
- R10: Dropping `iss_valid` during a stall returns the controller to IDLE. In that cycle no output is asserted.
- R11: `wb_valid` and `stall` are never high together, and `miss` never appears without `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Row configuration write strobe |
| cfg_row | input | 2 | Row index to configure |
| cfg_tag | input | 6 | Operation tag for the row |
| cfg_srcs | input | 15 | Three 5-bit source register indices, slot 0 in the low bits |
| cfg_fsel | input | 3 | Function select |
| rf_we | input | 1 | Register file write strobe |
| rf_waddr | input | 5 | Register file write index |
| rf_wdata | input | 32 | Register file write data |
| iss_valid | input | 1 | Custom opcode issued this cycle |
| iss_op | input | 6 | Issued custom opcode |
| stall | output | 1 | Pipeline stall request |
| miss | output | 1 | No loaded row carries the issued tag |
| wb_valid | output | 1 | Writeback data valid |
| wb_data | output | 32 | Writeback data |

## Verification
The checker assumes the pipeline keeps `iss_op` stable while `stall` is high, and that it withdraws the issue only by lowering `iss_valid`. The bench drives every issue this way, changing the opcode only in cycles where `iss_valid` is low or the previous cycle ended with a writeback. Configuration writes and register writes may land during a stall, including writes that resolve a pending miss. The bench uses these on purpose to exercise the MISS→WAIT path and the rule that a configuration write beats a register write at the same edge.

// File: rtl/rfu_pkg.sv
package rfu_pkg;

    localparam int FSEL_W = 3;

    localparam logic [FSEL_W-1:0] FN_ADD  = 3'd0;
    localparam logic [FSEL_W-1:0] FN_XOR  = 3'd1;
    localparam logic [FSEL_W-1:0] FN_AND  = 3'd2;
    localparam logic [FSEL_W-1:0] FN_OR   = 3'd3;
    localparam logic [FSEL_W-1:0] FN_BREV = 3'd4;
    localparam logic [FSEL_W-1:0] FN_ADD3 = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MISS = 2'd2
    } disp_state_e;

endpackage

// File: rtl/rfu_row.sv
module rfu_row
    import rfu_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_IDX_W = 5,
    parameter int TAG_W     = 6,
    parameter int NUM_SRC   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_load,
    input  logic [TAG_W-1:0]              cfg_tag,
    input  logic [NUM_SRC*REG_IDX_W-1:0]  cfg_srcs,
    input  logic [FSEL_W-1:0]             cfg_fsel,
    input  logic                          rf_we,
    input  logic [REG_IDX_W-1:0]          rf_waddr,
    input  logic [DATA_W-1:0]             rf_wdata,
    output logic                          row_live,
    output logic [TAG_W-1:0]              row_tag,
    output logic                          res_valid,
    output logic [DATA_W-1:0]             res_data
);

    logic                 live_q;
    logic [TAG_W-1:0]     tag_q;
    logic [FSEL_W-1:0]    fsel_q;
    logic [REG_IDX_W-1:0] src_q  [NUM_SRC];
    logic [DATA_W-1:0]    opnd_q [NUM_SRC];
    logic [NUM_SRC-1:0]   rdy_q;
    logic [NUM_SRC-1:0]   slot_hit;
    logic [NUM_SRC-1:0]   used;
    logic [DATA_W-1:0]    fn_out;
    logic                 val_q;
    logic [DATA_W-1:0]    res_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            tag_q  <= '0;
            fsel_q <= '0;
        end else if (cfg_load) begin
            live_q <= 1'b1;
            tag_q  <= cfg_tag;
            fsel_q <= cfg_fsel;
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
        assign slot_hit[s] = rf_we && live_q && (rf_waddr == src_q[s]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q[s]  <= '0;
                opnd_q[s] <= '0;
                rdy_q[s]  <= 1'b0;
            end else if (cfg_load) begin
                src_q[s]  <= cfg_srcs[s*REG_IDX_W +: REG_IDX_W];
                rdy_q[s]  <= 1'b0;
            end else if (slot_hit[s]) begin
                opnd_q[s] <= rf_wdata;
                rdy_q[s]  <= 1'b1;
            end
        end
    end

    always_comb begin
        used    = '0;
        used[0] = 1'b1;
        if (fsel_q == FN_ADD3) begin
            used[1] = 1'b1;
            used[2] = 1'b1;
        end else if (fsel_q != FN_BREV) begin
            used[1] = 1'b1;
        end
    end

    always_comb begin
        fn_out = '0;
        case (fsel_q)
            FN_ADD:  fn_out = opnd_q[0] + opnd_q[1];
            FN_XOR:  fn_out = opnd_q[0] ^ opnd_q[1];
            FN_AND:  fn_out = opnd_q[0] & opnd_q[1];
            FN_OR:   fn_out = opnd_q[0] | opnd_q[1];
            FN_BREV: begin
                for (int i = 0; i < DATA_W; i++) begin
                    fn_out[i] = opnd_q[0][DATA_W-1-i];
                end
            end
            FN_ADD3: fn_out = opnd_q[0] + opnd_q[1] + opnd_q[2];
            default: fn_out = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= 1'b0;
            res_q <= '0;
        end else if (cfg_load) begin
            val_q <= 1'b0;
            res_q <= '0;
        end else begin
            val_q <= ((rdy_q & used) == used) && !(|(slot_hit & used));
            res_q <= fn_out;
        end
    end

    assign row_live  = live_q;
    assign row_tag   = tag_q;
    assign res_valid = val_q;
    assign res_data  = res_q;

endmodule

// File: rtl/rfu_match.sv
module rfu_match #(
    parameter int NUM_ROWS  = 4,
    parameter int TAG_W     = 6,
    localparam int ROW_IDX_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic [NUM_ROWS-1:0]       live,
    input  logic [NUM_ROWS*TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]          op,
    output logic                      hit,
    output logic [ROW_IDX_W-1:0]      idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int r = NUM_ROWS - 1; r >= 0; r--) begin
            if (live[r] && (tags[r*TAG_W +: TAG_W] == op)) begin
                hit = 1'b1;
                idx = ROW_IDX_W'(r);
            end
        end
    end

endmodule

// File: rtl/rfu_issue_fsm.sv
module rfu_issue_fsm
    import rfu_pkg::*;
#(
    parameter int NUM_ROWS  = 4,
    parameter int DATA_W    = 32,
    localparam int ROW_IDX_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       iss_valid,
    input  logic                       look_hit,
    input  logic [ROW_IDX_W-1:0]       look_idx,
    input  logic [NUM_ROWS-1:0]        row_valid,
    input  logic [NUM_ROWS*DATA_W-1:0] row_data,
    output logic                       stall,
    output logic                       miss,
    output logic                       wb_valid,
    output logic [DATA_W-1:0]          wb_data
);

    disp_state_e          st_q, st_d;
    logic [ROW_IDX_W-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            wait_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d == ST_WAIT && st_q != ST_WAIT) begin
                wait_q <= look_idx;
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        stall    = 1'b0;
        miss     = 1'b0;
        wb_valid = 1'b0;
        wb_data  = '0;
        unique case (st_q)
            ST_IDLE, ST_MISS: begin
                if (!iss_valid) begin
                    st_d = ST_IDLE;
                end else if (!look_hit) begin
                    stall = 1'b1;
                    miss  = 1'b1;
                    st_d  = ST_MISS;
                end else if (row_valid[look_idx]) begin
                    wb_valid = 1'b1;
                    wb_data  = row_data[look_idx*DATA_W +: DATA_W];
                    st_d     = ST_IDLE;
                end else begin
                    stall = 1'b1;
                    st_d  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!iss_valid) begin
                    st_d = ST_IDLE;
                end else if (row_valid[wait_q]) begin
                    wb_valid = 1'b1;
                    wb_data  = row_data[wait_q*DATA_W +: DATA_W];
                    st_d     = ST_IDLE;
                end else begin
                    stall = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/rfu_dispatch.sv
module rfu_dispatch
    import rfu_pkg::*;
#(
    parameter int NUM_ROWS  = 4,
    parameter int TAG_W     = 6,
    parameter int REG_IDX_W = 5,
    parameter int NUM_SRC   = 3,
    parameter int DATA_W    = 32,
    localparam int ROW_IDX_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    localparam int SRC_BUS_W = NUM_SRC * REG_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ROW_IDX_W-1:0] cfg_row,
    input  logic [TAG_W-1:0]     cfg_tag,
    input  logic [SRC_BUS_W-1:0] cfg_srcs,
    input  logic [FSEL_W-1:0]    cfg_fsel,
    input  logic                 rf_we,
    input  logic [REG_IDX_W-1:0] rf_waddr,
    input  logic [DATA_W-1:0]    rf_wdata,
    input  logic                 iss_valid,
    input  logic [TAG_W-1:0]     iss_op,
    output logic                 stall,
    output logic                 miss,
    output logic                 wb_valid,
    output logic [DATA_W-1:0]    wb_data
);

    logic [NUM_ROWS-1:0]        row_live;
    logic [NUM_ROWS-1:0]        row_valid;
    logic [NUM_ROWS*TAG_W-1:0]  row_tags;
    logic [NUM_ROWS*DATA_W-1:0] row_data;
    logic                       look_hit;
    logic [ROW_IDX_W-1:0]       look_idx;

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        rfu_row #(
            .DATA_W    (DATA_W),
            .REG_IDX_W (REG_IDX_W),
            .TAG_W     (TAG_W),
            .NUM_SRC   (NUM_SRC)
        ) u_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_load  (cfg_we && (cfg_row == ROW_IDX_W'(r))),
            .cfg_tag   (cfg_tag),
            .cfg_srcs  (cfg_srcs),
            .cfg_fsel  (cfg_fsel),
            .rf_we     (rf_we),
            .rf_waddr  (rf_waddr),
            .rf_wdata  (rf_wdata),
            .row_live  (row_live[r]),
            .row_tag   (row_tags[r*TAG_W +: TAG_W]),
            .res_valid (row_valid[r]),
            .res_data  (row_data[r*DATA_W +: DATA_W])
        );
    end

    rfu_match #(
        .NUM_ROWS (NUM_ROWS),
        .TAG_W    (TAG_W)
    ) u_match (
        .live (row_live),
        .tags (row_tags),
        .op   (iss_op),
        .hit  (look_hit),
        .idx  (look_idx)
    );

    rfu_issue_fsm #(
        .NUM_ROWS (NUM_ROWS),
        .DATA_W   (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid),
        .look_hit  (look_hit),
        .look_idx  (look_idx),
        .row_valid (row_valid),
        .row_data  (row_data),
        .stall     (stall),
        .miss      (miss),
        .wb_valid  (wb_valid),
        .wb_data   (wb_data)
    );

endmodule

// File: rtl/rfu_dispatch_chk.sv
module rfu_dispatch_chk #(
    parameter int NUM_ROWS  = 4,
    parameter int ROW_IDX_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 iss_valid,
    input logic                 stall,
    input logic                 miss,
    input logic                 wb_valid,
    input logic                 cfg_we,
    input logic [ROW_IDX_W-1:0] cfg_row,
    input logic [NUM_ROWS-1:0]  row_valid
);

    a_r11_stall_wb_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && wb_valid));

    a_r11_miss_needs_stall: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> stall);

    a_r6_wb_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> iss_valid);

    a_r10_quiet_without_issue: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> !(stall || miss || wb_valid));

    a_r2_cfg_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !row_valid[$past(cfg_row)]);

endmodule

bind rfu_dispatch rfu_dispatch_chk #(
    .NUM_ROWS  (NUM_ROWS),
    .ROW_IDX_W (ROW_IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .stall     (stall),
    .miss      (miss),
    .wb_valid  (wb_valid),
    .cfg_we    (cfg_we),
    .cfg_row   (cfg_row),
    .row_valid (row_valid)
);

// File: tb/rfu_dispatch_tb.sv
module rfu_dispatch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_row = '0;
    logic [5:0]  cfg_tag = '0;
    logic [14:0] cfg_srcs = '0;
    logic [2:0]  cfg_fsel = '0;
    logic        rf_we = 1'b0;
    logic [4:0]  rf_waddr = '0;
    logic [31:0] rf_wdata = '0;
    logic        iss_valid = 1'b0;
    logic [5:0]  iss_op = '0;
    logic        stall, miss, wb_valid;
    logic [31:0] wb_data;

    always #10 clk = ~clk;

    rfu_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
        .cfg_tag(cfg_tag), .cfg_srcs(cfg_srcs), .cfg_fsel(cfg_fsel),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .iss_valid(iss_valid), .iss_op(iss_op), .stall(stall), .miss(miss),
        .wb_valid(wb_valid), .wb_data(wb_data)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference state
    bit          m_live [4];
    logic [5:0]  m_tag  [4];
    logic [2:0]  m_fsel [4];
    logic [4:0]  m_src  [4][3];
    logic [31:0] m_opv  [4][3];
    bit          m_rdy  [4][3];
    logic [31:0] m_res  [4];
    bit          m_val  [4];
    int          m_st = 0;   // 0 idle, 1 wait, 2 miss
    int          m_wait = 0;

    logic        obs_stall, obs_miss, obs_wbv;
    logic [31:0] obs_wbd;

    function automatic bit uses(logic [2:0] f, int s);
        if (s == 0) return 1;
        if (f == 3'd4) return 0;
        if (s == 1) return 1;
        return (f == 3'd5);
    endfunction

    function automatic logic [31:0] eval(logic [2:0] f, logic [31:0] a, logic [31:0] b, logic [31:0] c);
        logic [31:0] rv;
        case (f)
            3'd0: return a + b;
            3'd1: return a ^ b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: begin
                for (int i = 0; i < 32; i++) rv[i] = a[31 - i];
                return rv;
            end
            3'd5: return a + b + c;
            default: return 32'd0;
        endcase
    endfunction

    function automatic int lookup();
        for (int r = 0; r < 4; r++) if (m_live[r] && m_tag[r] == iss_op) return r;
        return -1;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic model_compare();
        bit e_st = 0, e_mi = 0, e_wb = 0;
        logic [31:0] e_d = '0;
        int idx;
        if (iss_valid) begin
            if (m_st == 1) begin
                if (m_val[m_wait]) begin e_wb = 1; e_d = m_res[m_wait]; end
                else e_st = 1;
            end else begin
                idx = lookup();
                if (idx < 0) begin e_st = 1; e_mi = 1; end
                else if (m_val[idx]) begin e_wb = 1; e_d = m_res[idx]; end
                else e_st = 1;
            end
        end
        check("R7 stall", {31'd0, stall}, {31'd0, e_st});
        check("R8 miss", {31'd0, miss}, {31'd0, e_mi});
        check("R6 wb_valid", {31'd0, wb_valid}, {31'd0, e_wb});
        if (e_wb) check("R5 wb_data", wb_data, e_d);
    endtask

    task automatic model_update();
        int idx;
        bit nv [4];
        logic [31:0] nr [4];
        bit h;
        if (m_st == 1) begin
            if (!iss_valid || m_val[m_wait]) m_st = 0;
        end else if (!iss_valid) begin
            m_st = 0;
        end else begin
            idx = lookup();
            if (idx < 0) m_st = 2;
            else if (m_val[idx]) m_st = 0;
            else begin m_st = 1; m_wait = idx; end
        end
        for (int r = 0; r < 4; r++) begin
            nv[r] = 1;
            for (int s = 0; s < 3; s++) begin
                h = rf_we && m_live[r] && (rf_waddr == m_src[r][s]);
                if (uses(m_fsel[r], s) && (!m_rdy[r][s] || h)) nv[r] = 0;
            end
            nr[r] = eval(m_fsel[r], m_opv[r][0], m_opv[r][1], m_opv[r][2]);
        end
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < 3; s++) begin
                if (rf_we && m_live[r] && (rf_waddr == m_src[r][s])) begin
                    m_opv[r][s] = rf_wdata;
                    m_rdy[r][s] = 1;
                end
            end
            m_val[r] = nv[r];
            m_res[r] = nr[r];
            if (cfg_we && cfg_row == r[1:0]) begin
                m_live[r] = 1;
                m_tag[r]  = cfg_tag;
                m_fsel[r] = cfg_fsel;
                m_val[r]  = 0;
                m_res[r]  = '0;
                for (int s = 0; s < 3; s++) begin
                    m_src[r][s] = cfg_srcs[s*5 +: 5];
                    m_rdy[r][s] = 0;
                end
            end
        end
    endtask

    // inputs are set right after a falling edge; tick samples, compares and advances
    task automatic tick();
        #5;
        obs_stall = stall; obs_miss = miss; obs_wbv = wb_valid; obs_wbd = wb_data;
        model_compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
        cfg_we = 0;
        rf_we = 0;
    endtask

    task automatic load_row(int row, logic [5:0] tag, logic [4:0] s0, logic [4:0] s1, logic [4:0] s2, logic [2:0] f);
        cfg_we = 1; cfg_row = row[1:0]; cfg_tag = tag; cfg_srcs = {s2, s1, s0}; cfg_fsel = f;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        rf_we = 1; rf_waddr = a; rf_wdata = d;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 4; r++) begin
            m_live[r] = 0; m_tag[r] = '0; m_fsel[r] = '0; m_res[r] = '0; m_val[r] = 0;
            for (int s = 0; s < 3; s++) begin m_src[r][s] = '0; m_opv[r][s] = '0; m_rdy[r][s] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        tick();
        check("R1 stall", {31'd0, obs_stall}, 0);
        check("R1 wb_valid", {31'd0, obs_wbv}, 0);
        iss_valid = 1; iss_op = 6'h0A;
        tick();
        check("R1 miss", {31'd0, obs_miss}, 1);
        check("R8 stall", {31'd0, obs_stall}, 1);

        // R8 resolved by loading the tag during the miss
        load_row(0, 6'h0A, 5'd1, 5'd2, 5'd3, 3'd0);
        tick();
        check("R8 miss held", {31'd0, obs_miss}, 1);
        tick();
        check("R8 miss cleared", {31'd0, obs_miss}, 0);
        check("R7 stall on hit", {31'd0, obs_stall}, 1);

        // R3/R4/R7 late operands
        wr(5'd1, 32'd100); tick();
        wr(5'd2, 32'd23);  tick();
        tick();
        check("R4 one cycle lag", {31'd0, obs_stall}, 1);
        tick();
        check("R7 wb after stall", {31'd0, obs_wbv}, 1);
        check("R5 add", obs_wbd, 32'd123);
        iss_valid = 0;

        // R4 rewrite invalidates for one cycle
        wr(5'd2, 32'd50); tick();
        iss_valid = 1; tick();
        check("R4 rewrite stall", {31'd0, obs_stall}, 1);
        tick();
        check("R3 new operand", obs_wbd, 32'd150);
        iss_valid = 0;

        // R9 priority, R5 bit reverse, R4 single-slot use
        load_row(1, 6'h11, 5'd4, 5'd0, 5'd0, 3'd4); tick();
        load_row(2, 6'h11, 5'd5, 5'd6, 5'd7, 3'd5); tick();
        load_row(3, 6'h0A, 5'd1, 5'd2, 5'd0, 3'd1); tick();
        wr(5'd4, 32'h0000_0001); tick();
        tick();
        iss_valid = 1; iss_op = 6'h11; tick();
        check("R9 lowest row", {31'd0, obs_wbv}, 1);
        check("R5 brev", obs_wbd, 32'h8000_0000);
        iss_valid = 0; tick();
        iss_valid = 1; iss_op = 6'h0A; tick();
        check("R9 row0 over row3", obs_wbd, 32'd150);
        check("R6 no stall", {31'd0, obs_stall}, 0);
        iss_valid = 0;

        // R4 three-slot use
        load_row(2, 6'h22, 5'd5, 5'd6, 5'd7, 3'd5); tick();
        wr(5'd5, 32'd1); tick();
        wr(5'd6, 32'd2); tick();
        tick();
        iss_valid = 1; iss_op = 6'h22; tick();
        check("R4 third slot pending", {31'd0, obs_stall}, 1);
        iss_valid = 0;
        wr(5'd7, 32'd4); tick();
        tick();
        iss_valid = 1; tick();
        check("R5 add3", obs_wbd, 32'd7);
        iss_valid = 0;

        // R10 withdrawn issue
        load_row(3, 6'h33, 5'd8, 5'd9, 5'd0, 3'd3); tick();
        iss_valid = 1; iss_op = 6'h33; tick();
        check("R10 stall first", {31'd0, obs_stall}, 1);
        iss_valid = 0; tick();
        check("R10 quiet", {29'd0, obs_stall, obs_miss, obs_wbv}, 0);
        wr(5'd8, 32'hF0); tick();
        wr(5'd9, 32'h0F); tick();
        tick();
        iss_valid = 1; tick();
        check("R5 or", obs_wbd, 32'hFF);
        iss_valid = 0;

        // R5 remaining selects
        for (int k = 0; k < 3; k++) begin
            logic [2:0] f;
            logic [31:0] e;
            f = (k == 0) ? 3'd1 : (k == 1) ? 3'd2 : 3'd6;
            e = (k == 0) ? 32'h0FF0 : (k == 1) ? 32'hF000 : 32'd0;
            load_row(3, 6'h33, 5'd8, 5'd9, 5'd0, f); tick();
            wr(5'd8, 32'hF0F0); tick();
            wr(5'd9, 32'hFF00); tick();
            tick();
            iss_valid = 1; tick();
            check("R5 select", obs_wbd, e);
            iss_valid = 0;
        end

        // R2 configuration beats same-edge register write
        load_row(3, 6'h33, 5'd8, 5'd9, 5'd0, 3'd3); wr(5'd8, 32'h1); tick();
        wr(5'd9, 32'h2); tick();
        tick();
        iss_valid = 1; tick();
        check("R2 cfg wins", {31'd0, obs_stall}, 1);
        wr(5'd8, 32'h4); tick();
        tick();
        tick();
        check("R2 then resolves", obs_wbd, 32'h6);
        iss_valid = 0; tick();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule